// File: doc/BRIEF.md
# Flash Rewrite Mode Controller

This block sits between a CPU register/command port and a small on-chip flash array. The array is modelled as registers with fixed program and erase durations. Software arms a CPU rewrite mode through a control register, and may also arm a second variant ("interrupt-driven" mode, called EW1 here; the base variant is EW0). It then issues word-program and block-erase commands, which a busy counter sequences. A ready flag, a program-error flag and an erase-error flag report the outcome. In EW0 the read port switches to a status byte after each operation. In EW1 the read port stays on the array.

An erase can be paused and resumed. In EW0, software sets a suspend-enable bit and a suspend-request bit. In EW1, an interrupt pulse raises the suspend request by itself. The erase pauses a fixed number of cycles after the request, and array reads then become valid. The block refuses commands aimed at protected blocks. Blocks 0 and 1 are protected unless an unlock bit is set. In EW1, the block that holds the running rewrite code and the top block (interrupt vectors) are also protected.

Top module: `flash_rewrite_ctrl`

## Requirements
- R1: Control register 0 (reg_sel=0) bit 0 (rewrite enable) becomes 1 only when the write that sets bit 0 directly follows a control-register-0 write that had bit 0 clear. Once set, it stays 1 on writes of 1 and clears on a write of 0. A write of 1 after any other history leaves it 0.
- R2: Entering or leaving rewrite mode forces control register 1 (reg_sel=1) bit 0 (EW1 select) to 0. EW1 select is armed by the same 0-then-1 sequence on control register 1, and only while rewrite enable is 1.
- R3: While rewrite enable is 0, commands are ignored: ready stays 1 and the array is unchanged.
- R4: An accepted program (cmd_op=0) or block erase (cmd_op=1) clears ready (control register 0 bit 5) for exactly PROG_CYC or ERASE_CYC cycles. Program stores cmd_data at cmd_addr. Erase sets every word of the addressed block (address bits above BLK_WORDS_W) to all ones.
- R5: In EW0, the read port switches to status after an operation or after a read-status command (cmd_op=2). Status is rd_status_sel=1 and rd_data = {ready, 0, erase error, program error, 0000}. A read-array command (cmd_op=3) switches it back.
- R6: In EW1, the read-status command is ignored, and the read port stays on the array after an operation.
- R7: Program or erase aimed at blocks 0 or 1 is refused while control register 1 bit 1 (unlock) is 0. A refused command sets program error (bit 6) or erase error (bit 7) of control register 0, does not start, and leaves the array unchanged.
- R8: In EW1, program or erase aimed at the block given by code_blk or at the top block is refused as in R7. In EW0 these blocks are writable.
- R9: In EW0 during an erase, control register 0 bit 1 (suspend enable) and bit 2 (suspend request) both set make the suspend flag (bit 3) rise SUSP_LAT cycles after the request is written. Ready then stays 0 and rd_valid is 1 with array data readable.
- R10: Clearing the suspend request while suspended resumes the erase, which then completes and erases the block.
- R11: In EW1 with suspend enable set, a one-cycle irq_req pulse during an erase sets the suspend request. The suspend flag then rises SUSP_LAT cycles after the pulse.
- R12: Both error flags clear when a program or erase command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_sel | input | 1 | 0 selects control register 0, 1 selects control register 1 |
| reg_wdata | input | 8 | Control register write data |
| ctl0_rd | output | 8 | Control register 0: {erase err, prog err, ready, 0, suspended, susp req, susp en, rewrite en} |
| ctl1_rd | output | 8 | Control register 1: {000000, unlock, EW1 select} |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 program, 1 block erase, 2 read status, 3 read array |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_data | input | DATA_W | Program data |
| code_blk | input | ADDR_W-BLK_WORDS_W | Block holding the running rewrite code |
| irq_req | input | 1 | Interrupt request pulse |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word, or status byte when rd_status_sel is 1 |
| rd_valid | output | 1 | Array data is valid (idle or suspended) |
| rd_status_sel | output | 1 | Read port currently shows status |

## Verification
On every cycle, the assertions check four things. An armed rewrite bit never appears without the preceding 0 write. Entering rewrite mode never leaves EW1 selected. An accepted command always drops ready, and a refused one always raises an error flag. The suspend flag only rises during an erase, and an interrupt during an erase in EW1 always raises the suspend request. Other behaviour is shown only by the bench's scenarios: the exact program, erase and suspend durations, the resume that completes the erase, the array contents that protection keeps intact, and the read-port switching between status and array in the two modes.

// File: rtl/fr_pkg.sv
package fr_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_RDSR  = 2'd2,
    OP_RDARR = 2'd3
  } fr_op_e;

  // Protection rule: low blocks need unlock; in EW1 the code block and
  // the top (vector) block are also off limits.
  function automatic logic fr_refuse(input logic ew1, input logic unlock,
                                     input int unsigned blk,
                                     input int unsigned code_blk,
                                     input int unsigned top_blk);
    return (blk < 2 && !unlock) || (ew1 && (blk == code_blk || blk == top_blk));
  endfunction

  function automatic logic [7:0] fr_status(input logic ready, input logic eerr,
                                           input logic perr);
    return {ready, 1'b0, eerr, perr, 4'b0000};
  endfunction

endpackage

// File: rtl/fr_mode_regs.sv
module fr_mode_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       sel,
  input  logic [7:0] wdata,
  input  logic       irq,
  input  logic       erasing,
  output logic       rewrite_en,
  output logic       ew1,
  output logic       unlock,
  output logic       susp_en,
  output logic       susp_req
);
  logic prev0_zero, prev1_zero;
  logic irq_susp;

  assign irq_susp = ew1 && susp_en && erasing && irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rewrite_en <= 1'b0;
      ew1        <= 1'b0;
      unlock     <= 1'b0;
      susp_en    <= 1'b0;
      susp_req   <= 1'b0;
      prev0_zero <= 1'b0;
      prev1_zero <= 1'b0;
    end else begin
      if (we && !sel) begin
        prev0_zero <= !wdata[0];
        rewrite_en <= wdata[0] && (rewrite_en || prev0_zero);
        if (!wdata[0] || (!rewrite_en && prev0_zero)) ew1 <= 1'b0;
        susp_en    <= wdata[1];
        susp_req   <= wdata[2];
      end
      if (we && sel) begin
        prev1_zero <= !wdata[0];
        ew1        <= wdata[0] && rewrite_en && (ew1 || prev1_zero);
        unlock     <= wdata[1];
      end
      if (irq_susp) susp_req <= 1'b1;
    end
  end

  assert_arm_seq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sel && wdata[0] && !rewrite_en && !prev0_zero) |=> !rewrite_en);

  assert_enter_ew0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rewrite_en) |-> !ew1);

  assert_irq_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_susp |=> susp_req);
endmodule

// File: rtl/fr_guard.sv
module fr_guard #(
  parameter int ADDR_W      = 6,
  parameter int BLK_WORDS_W = 3
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          ew1,
  input  logic                          unlock,
  input  logic [ADDR_W-BLK_WORDS_W-1:0] code_blk,
  output logic                          refuse
);
  localparam int BLK_W   = ADDR_W - BLK_WORDS_W;
  localparam int TOP_BLK = (1 << BLK_W) - 1;

  logic [BLK_W-1:0] blk;
  assign blk    = addr[ADDR_W-1:BLK_WORDS_W];
  assign refuse = fr_pkg::fr_refuse(ew1, unlock, 32'(blk), 32'(code_blk),
                                    32'(TOP_BLK));
endmodule

// File: rtl/fr_sequencer.sv
module fr_sequencer #(
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 20,
  parameter int SUSP_LAT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_erase,
  input  logic bad,
  input  logic bad_erase,
  input  logic rdsr,
  input  logic rdarr,
  input  logic ew1,
  input  logic susp_en,
  input  logic susp_req,
  output logic ready,
  output logic erasing,
  output logic susp_flag,
  output logic done,
  output logic op_erase,
  output logic prog_err,
  output logic erase_err,
  output logic status_mode
);
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int LAT_W = $clog2(SUSP_LAT + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [LAT_W-1:0] lat;
  logic             susp_arm;
  logic             susp_hit;

  assign ready    = !busy;
  assign erasing  = busy && op_erase;
  assign done     = busy && !susp_flag && cnt == CNT_W'(1);
  assign susp_arm = erasing && !susp_flag && !done && susp_en && susp_req;
  assign susp_hit = susp_arm && lat == LAT_W'(SUSP_LAT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      op_erase  <= 1'b0;
      cnt       <= '0;
      lat       <= '0;
      susp_flag <= 1'b0;
    end else if (go) begin
      busy      <= 1'b1;
      op_erase  <= go_erase;
      cnt       <= go_erase ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
      lat       <= '0;
      susp_flag <= 1'b0;
    end else if (busy) begin
      if (susp_flag) begin
        if (!susp_req) susp_flag <= 1'b0;
      end else begin
        if (done) busy <= 1'b0;
        else      cnt  <= cnt - CNT_W'(1);
        if (susp_hit)      begin susp_flag <= 1'b1; lat <= '0; end
        else if (susp_arm) lat <= lat + LAT_W'(1);
        else               lat <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_err    <= 1'b0;
      erase_err   <= 1'b0;
      status_mode <= 1'b0;
    end else begin
      if (go) begin
        prog_err  <= 1'b0;
        erase_err <= 1'b0;
      end else if (bad) begin
        if (bad_erase) erase_err <= 1'b1;
        else           prog_err  <= 1'b1;
      end
      if (done)          status_mode <= !ew1;
      else if (susp_hit) status_mode <= 1'b0;
      else if (rdsr)     status_mode <= 1'b1;
      else if (rdarr)    status_mode <= 1'b0;
    end
  end

  assert_susp_in_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_flag) |-> (busy && op_erase));

  assert_susp_holds_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    susp_flag |-> !ready);
endmodule

// File: rtl/flash_rewrite_ctrl.sv
module flash_rewrite_ctrl #(
  parameter int ADDR_W      = 6,
  parameter int BLK_WORDS_W = 3,
  parameter int DATA_W      = 8,
  parameter int PROG_CYC    = 4,
  parameter int ERASE_CYC   = 20,
  parameter int SUSP_LAT    = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic                          reg_sel,
  input  logic [7:0]                    reg_wdata,
  output logic [7:0]                    ctl0_rd,
  output logic [7:0]                    ctl1_rd,
  input  logic                          cmd_valid,
  input  logic [1:0]                    cmd_op,
  input  logic [ADDR_W-1:0]             cmd_addr,
  input  logic [DATA_W-1:0]             cmd_data,
  input  logic [ADDR_W-BLK_WORDS_W-1:0] code_blk,
  input  logic                          irq_req,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_valid,
  output logic                          rd_status_sel
);
  import fr_pkg::*;
  localparam int WORDS = 1 << ADDR_W;

  logic rewrite_en, ew1, unlock, susp_en, susp_req;
  logic ready, erasing, susp_flag, done, op_erase;
  logic prog_err, erase_err, status_mode;
  logic refuse, accept, is_wr, go, bad, rdsr, rdarr;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [DATA_W-1:0] mem [WORDS];

  fr_mode_regs u_regs (
    .clk, .rst_n, .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .irq(irq_req), .erasing, .rewrite_en, .ew1, .unlock, .susp_en, .susp_req
  );

  fr_guard #(.ADDR_W(ADDR_W), .BLK_WORDS_W(BLK_WORDS_W)) u_guard (
    .addr(cmd_addr), .ew1, .unlock, .code_blk, .refuse
  );

  assign accept = cmd_valid && rewrite_en && ready;
  assign is_wr  = cmd_op == OP_PROG || cmd_op == OP_ERASE;
  assign go     = accept && is_wr && !refuse;
  assign bad    = accept && is_wr && refuse;
  assign rdsr   = accept && cmd_op == OP_RDSR && !ew1;
  assign rdarr  = accept && cmd_op == OP_RDARR;

  fr_sequencer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                 .SUSP_LAT(SUSP_LAT)) u_seq (
    .clk, .rst_n, .go, .go_erase(cmd_op == OP_ERASE), .bad,
    .bad_erase(cmd_op == OP_ERASE), .rdsr, .rdarr, .ew1, .susp_en, .susp_req,
    .ready, .erasing, .susp_flag, .done, .op_erase, .prog_err, .erase_err,
    .status_mode
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_addr <= '0;
      op_data <= '0;
    end else if (go) begin
      op_addr <= cmd_addr;
      op_data <= cmd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '1;
    end else if (done && !op_erase) begin
      mem[op_addr] <= op_data;
    end else if (done && op_erase) begin
      for (int w = 0; w < WORDS; w++)
        if ((ADDR_W'(w) >> BLK_WORDS_W) == (op_addr >> BLK_WORDS_W)) mem[w] <= '1;
    end
  end

  assign ctl0_rd = {erase_err, prog_err, ready, 1'b0, susp_flag, susp_req,
                    susp_en, rewrite_en};
  assign ctl1_rd = {6'b0, unlock, ew1};
  assign rd_status_sel = status_mode;
  assign rd_valid = ready || susp_flag;
  assign rd_data  = status_mode ? DATA_W'(fr_status(ready, erase_err, prog_err))
                                : mem[rd_addr];

  assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !ready);

  assert_refuse_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (prog_err || erase_err) && ready);
endmodule

// File: tb/flash_rewrite_ctrl_test.sv
module flash_rewrite_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6, BLK_WORDS_W = 3, DATA_W = 8;
  localparam int PROG_CYC = 4, ERASE_CYC = 20, SUSP_LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] ctl0_rd, ctl1_rd;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [ADDR_W-1:0] cmd_addr = 0, rd_addr = 0;
  logic [DATA_W-1:0] cmd_data = 0, rd_data;
  logic [ADDR_W-BLK_WORDS_W-1:0] code_blk = 3;
  logic irq_req = 0, rd_valid, rd_status_sel;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rewrite_ctrl #(.ADDR_W(ADDR_W), .BLK_WORDS_W(BLK_WORDS_W), .DATA_W(DATA_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT)) uut (
    .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .ctl0_rd, .ctl1_rd,
    .cmd_valid, .cmd_op, .cmd_addr, .cmd_data, .code_blk, .irq_req,
    .rd_addr, .rd_data, .rd_valid, .rd_status_sel);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic s, input logic [7:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic cmd(input logic [1:0] op, input int a, input int d);
    cmd_valid = 1; cmd_op = op; cmd_addr = ADDR_W'(a); cmd_data = DATA_W'(d);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ctl0_rd[5] && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_susp(output int n);
    n = 0;
    while (!ctl0_rd[3] && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic peek(input int a, output int v);
    rd_addr = ADDR_W'(a); #1; v = int'(rd_data);
  endtask

  task automatic enter_rewrite();
    wr_reg(0, 8'h00); wr_reg(0, 8'h01);
  endtask

  task automatic t_reset();
    check(ctl0_rd == 8'h20, "R4 reset ctl0", ctl0_rd, 8'h20);
    check(ctl1_rd == 8'h00, "R2 reset ctl1", ctl1_rd, 0);
  endtask

  task automatic t_arm();
    wr_reg(0, 8'h01);
    check(ctl0_rd[0] == 0, "R1 lone 1 write", ctl0_rd[0], 0);
    enter_rewrite();
    check(ctl0_rd[0] == 1, "R1 0-then-1 arms", ctl0_rd[0], 1);
    wr_reg(1, 8'h01);
    check(ctl1_rd[0] == 0, "R2 lone 1 on ctl1", ctl1_rd[0], 0);
    wr_reg(1, 8'h00); wr_reg(1, 8'h01);
    check(ctl1_rd[0] == 1, "R2 ew1 armed", ctl1_rd[0], 1);
    enter_rewrite();
    check(ctl1_rd[0] == 0 && ctl0_rd[0] == 1, "R2 entry clears ew1", ctl1_rd, 0);
    wr_reg(0, 8'h00); wr_reg(1, 8'h00); wr_reg(1, 8'h01);
    check(ctl1_rd[0] == 0, "R2 ew1 needs rewrite mode", ctl1_rd[0], 0);
  endtask

  task automatic t_cmd_off();
    int v;
    cmd(0, 20, 8'h5A);
    check(ctl0_rd[5] == 1, "R3 ready stays", ctl0_rd[5], 1);
    repeat (PROG_CYC + 2) @(negedge clk);
    peek(20, v);
    check(v == 8'hFF && rd_status_sel == 0, "R3 array untouched", v, 8'hFF);
  endtask

  task automatic t_program_ew0();
    int n, v;
    enter_rewrite();
    cmd(0, 20, 8'h5A);
    wait_ready(n);
    check(n == PROG_CYC, "R4 program duration", n, PROG_CYC);
    peek(20, v);
    check(rd_status_sel == 1 && v == 8'h80, "R5 status after program", v, 8'h80);
    cmd(3, 0, 0);
    peek(20, v);
    check(v == 8'h5A && rd_valid, "R4 program data", v, 8'h5A);
    cmd(0, 60, 8'hA5);
    wait_ready(n);
    cmd(3, 0, 0);
    peek(60, v);
    check(v == 8'hA5, "R8 top block writable in EW0", v, 8'hA5);
  endtask

  task automatic t_erase();
    int n, v;
    cmd(1, 16, 0);
    wait_ready(n);
    check(n == ERASE_CYC, "R4 erase duration", n, ERASE_CYC);
    cmd(3, 0, 0);
    peek(20, v);
    check(v == 8'hFF, "R4 block erased", v, 8'hFF);
  endtask

  task automatic t_protect();
    int n, v;
    cmd(0, 3, 8'h33);
    check(ctl0_rd[6] == 1 && ctl0_rd[5] == 1, "R7 low block program refused", ctl0_rd, 8'h60);
    cmd(2, 0, 0);
    peek(0, v);
    check(rd_status_sel && v == 8'h90, "R5 read status shows prog error", v, 8'h90);
    cmd(1, 8, 0);
    check(ctl0_rd[7] == 1, "R7 low block erase refused", ctl0_rd, 8'hE0);
    cmd(3, 0, 0);
    peek(3, v);
    check(v == 8'hFF, "R7 array unchanged", v, 8'hFF);
    wr_reg(1, 8'h02);
    cmd(0, 3, 8'h33);
    check(ctl0_rd[7:6] == 0 && ctl0_rd[5] == 0, "R12 errors cleared on accept", ctl0_rd, 8'h01);
    wait_ready(n);
    cmd(3, 0, 0);
    peek(3, v);
    check(v == 8'h33, "R7 unlock allows low block", v, 8'h33);
  endtask

  task automatic t_ew1();
    int n, v;
    wr_reg(1, 8'h02); wr_reg(1, 8'h03);
    check(ctl1_rd == 8'h03, "R2 ew1 selected", ctl1_rd, 3);
    cmd(0, 24, 8'h44);
    check(ctl0_rd[6] == 1 && ctl0_rd[5] == 1, "R8 code block refused", ctl0_rd, 8'h61);
    cmd(0, 60, 8'h00);
    check(ctl0_rd[6] == 1, "R8 vector block refused", ctl0_rd, 8'h61);
    peek(60, v);
    check(v == 8'hA5, "R8 vector block unchanged", v, 8'hA5);
    cmd(0, 40, 8'hC3);
    wait_ready(n);
    peek(40, v);
    check(rd_status_sel == 0 && v == 8'hC3, "R6 array mode after program", v, 8'hC3);
    cmd(2, 0, 0);
    check(rd_status_sel == 0, "R6 read status ignored", rd_status_sel, 0);
  endtask

  task automatic t_susp_ew0();
    int n, v;
    enter_rewrite();
    cmd(0, 41, 8'h77);
    wait_ready(n);
    cmd(1, 40, 0);
    repeat (2) @(negedge clk);
    wr_reg(0, 8'h07);
    wait_susp(n);
    check(n == SUSP_LAT, "R9 suspend latency EW0", n, SUSP_LAT);
    repeat (8) @(negedge clk);
    peek(41, v);
    check(ctl0_rd[3] && !ctl0_rd[5] && rd_valid && v == 8'h77, "R9 suspended array read", v, 8'h77);
    wr_reg(0, 8'h03);
    wait_ready(n);
    check(ctl0_rd[3] == 0 && n > 0, "R10 resumed erase completes", ctl0_rd, 8'h23);
    cmd(3, 0, 0);
    peek(41, v);
    check(v == 8'hFF, "R10 block erased after resume", v, 8'hFF);
  endtask

  task automatic t_susp_ew1();
    int n, v;
    wr_reg(1, 8'h02); wr_reg(1, 8'h03);
    cmd(0, 50, 8'h11);
    wait_ready(n);
    wr_reg(0, 8'h03);
    cmd(1, 48, 0);
    repeat (2) @(negedge clk);
    irq_req = 1; @(negedge clk); irq_req = 0;
    check(ctl0_rd[2] == 1, "R11 irq sets request", ctl0_rd[2], 1);
    wait_susp(n);
    check(n == SUSP_LAT, "R11 suspend latency EW1", n, SUSP_LAT);
    peek(50, v);
    check(rd_valid && v == 8'h11, "R11 suspended array read", v, 8'h11);
    wr_reg(0, 8'h03);
    wait_ready(n);
    peek(50, v);
    check(v == 8'hFF && rd_status_sel == 0, "R10 EW1 resume erases", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_arm();
    t_cmd_off();
    t_program_ew0();
    t_erase();
    t_protect();
    t_ew1();
    t_susp_ew0();
    t_susp_ew1();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule